// File: doc/BRIEF.md
# Tone Burst Qualifier with Delayed Digit Strobe

This block follows a tone decoder. At every tick it looks at a tone-present flag and a digit code that comes with it, and it decides whether the burst is a real digit or noise. A burst has to stay present for a set number of consecutive ticks before it counts. Only then does the block latch the code onto its digit output. A strobe follows a fixed number of ticks later, so a consumer can capture the code on the strobe's rising edge and know it is already settled.

Once a digit has been accepted, short gaps in the tone do not disturb the outputs. A run of tone-absent ticks long enough to count as a pause clears the digit and the strobe together, and the block is then ready for the next burst. Every duration is counted in pulses of a one-cycle tick enable, and each one is a parameter. In cycles without a tick the block does nothing.

Top module: `tone_qual`

## Requirements
- R1: While reset is applied and after it is released, `digit_out` is 0 and `digit_strobe` is 0 until a burst is accepted.
- R2: A burst of fewer than ACC_TICKS consecutive tone-present ticks leaves `digit_out` and `digit_strobe` unchanged. No partial acceptance happens.
- R3: At the clock edge that samples the ACC_TICKS-th consecutive tone-present tick, `digit_out` takes the `code_in` value sampled on that tick, and `digit_strobe` stays 0.
- R4: `digit_strobe` rises at the edge that samples the STB_TICKS-th tick after acceptance, and `digit_out` does not change at that edge.
- R5: While a digit is held, changes on `code_in` do not reach `digit_out` until the outputs clear.
- R6: While a digit is held, a run of fewer than PAUSE_TICKS consecutive tone-absent ticks clears neither output.
- R7: While a digit is held, the edge that samples the PAUSE_TICKS-th consecutive tone-absent tick sets both `digit_out` and `digit_strobe` to 0.
- R8: In cycles where `tick` is 0, `tone_present` and `code_in` are ignored and neither output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | One-cycle enable that defines the unit of every duration |
| tone_present | input | 1 | Tone detected, sampled only on tick cycles |
| code_in | input | DIG_W | Digit code from the decoder |
| digit_out | output | DIG_W | Latched digit code, 0 when idle |
| digit_strobe | output | 1 | High while an accepted digit is presented |

## Verification
Both outputs are registered. Each result is therefore visible from the falling edge that follows the rising edge which sampled the deciding tick: the ACC_TICKS-th tone tick for the digit, the STB_TICKS-th tick after acceptance for the strobe, and the PAUSE_TICKS-th absent tick for the clear. The reset synchronizer adds two clocks after `rst_n` rises before the first tick is taken. The bench drives inputs on falling edges and advances a reference model on rising edges. It compares the outputs on every falling edge, and directed checks wait one idle falling edge after the last tick so that they sample in exactly that cycle.

// File: rtl/tone_qual_pkg.sv
package tone_qual_pkg;

  typedef enum logic [1:0] {
    TQ_IDLE  = 2'd0,
    TQ_ARMED = 2'd1,
    TQ_SHOWN = 2'd2
  } tq_state_e;

  function automatic int tq_max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/tone_qual_satcnt.sv
module tone_qual_satcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && inc && (cnt_q != '1)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tone_qual_ctrl.sv
module tone_qual_ctrl
  import tone_qual_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int ACC_TICKS   = 6,
  parameter int STB_TICKS   = 3,
  parameter int PAUSE_TICKS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tone,
  input  logic [CNT_W-1:0] run_cnt,
  input  logic [CNT_W-1:0] gap_cnt,
  input  logic [CNT_W-1:0] dly_cnt,
  output logic             run_clr,
  output logic             run_inc,
  output logic             gap_clr,
  output logic             gap_inc,
  output logic             dly_clr,
  output logic             dly_inc,
  output logic             load,
  output logic             set_stb,
  output logic             clr_out
);

  localparam logic [CNT_W-1:0] ACC_M1   = CNT_W'(ACC_TICKS - 1);
  localparam logic [CNT_W-1:0] STB_M1   = CNT_W'(STB_TICKS - 1);
  localparam logic [CNT_W-1:0] PAUSE_M1 = CNT_W'(PAUSE_TICKS - 1);

  tq_state_e st_q, st_d;
  logic      pause_hit;

  assign pause_hit = tick && !tone && (gap_cnt >= PAUSE_M1);

  always_comb begin
    st_d    = st_q;
    run_clr = 1'b1;
    run_inc = 1'b0;
    gap_clr = 1'b1;
    gap_inc = 1'b0;
    dly_clr = 1'b1;
    dly_inc = 1'b0;
    load    = 1'b0;
    set_stb = 1'b0;
    clr_out = 1'b0;
    unique case (st_q)
      TQ_IDLE: begin
        run_clr = tick && !tone;
        run_inc = tone;
        if (tick && tone && (run_cnt >= ACC_M1)) begin
          load    = 1'b1;
          run_clr = 1'b1;
          st_d    = TQ_ARMED;
        end
      end
      TQ_ARMED: begin
        gap_clr = tick && tone;
        gap_inc = !tone;
        dly_clr = 1'b0;
        dly_inc = 1'b1;
        if (pause_hit) begin
          clr_out = 1'b1;
          st_d    = TQ_IDLE;
        end else if (tick && (dly_cnt >= STB_M1)) begin
          set_stb = 1'b1;
          st_d    = TQ_SHOWN;
        end
      end
      TQ_SHOWN: begin
        gap_clr = tick && tone;
        gap_inc = !tone;
        if (pause_hit) begin
          clr_out = 1'b1;
          st_d    = TQ_IDLE;
        end
      end
      default: st_d = TQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/tone_qual_outreg.sv
module tone_qual_outreg #(
  parameter int DIG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             set_stb,
  input  logic             clr_out,
  input  logic [DIG_W-1:0] code,
  output logic [DIG_W-1:0] digit,
  output logic             stb
);

  logic [DIG_W-1:0] dig_q, dig_d;
  logic             stb_q, stb_d;

  always_comb begin
    dig_d = dig_q;
    stb_d = stb_q;
    if (clr_out) begin
      dig_d = '0;
      stb_d = 1'b0;
    end else begin
      if (load)    dig_d = code;
      if (set_stb) stb_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= '0;
      stb_q <= 1'b0;
    end else begin
      dig_q <= dig_d;
      stb_q <= stb_d;
    end
  end

  assign digit = dig_q;
  assign stb   = stb_q;

endmodule

// File: rtl/tone_qual.sv
module tone_qual
  import tone_qual_pkg::*;
#(
  parameter int DIG_W       = 4,
  parameter int ACC_TICKS   = 6,
  parameter int STB_TICKS   = 3,
  parameter int PAUSE_TICKS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tone_present,
  input  logic [DIG_W-1:0] code_in,
  output logic [DIG_W-1:0] digit_out,
  output logic             digit_strobe
);

  localparam int MAX_T = tq_max3(ACC_TICKS, STB_TICKS, PAUSE_TICKS);
  localparam int CNT_W = $clog2(MAX_T + 1) + 1;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  logic [CNT_W-1:0] run_cnt, gap_cnt, dly_cnt;
  logic run_clr, run_inc, gap_clr, gap_inc, dly_clr, dly_inc;
  logic load, set_stb, clr_out;

  tone_qual_satcnt #(.W(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_sync_n), .en(tick), .clr(run_clr), .inc(run_inc), .cnt(run_cnt)
  );

  tone_qual_satcnt #(.W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_sync_n), .en(tick), .clr(gap_clr), .inc(gap_inc), .cnt(gap_cnt)
  );

  tone_qual_satcnt #(.W(CNT_W)) u_dly (
    .clk(clk), .rst_n(rst_sync_n), .en(tick), .clr(dly_clr), .inc(dly_inc), .cnt(dly_cnt)
  );

  tone_qual_ctrl #(
    .CNT_W(CNT_W), .ACC_TICKS(ACC_TICKS), .STB_TICKS(STB_TICKS), .PAUSE_TICKS(PAUSE_TICKS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .tone(tone_present),
    .run_cnt(run_cnt), .gap_cnt(gap_cnt), .dly_cnt(dly_cnt),
    .run_clr(run_clr), .run_inc(run_inc), .gap_clr(gap_clr), .gap_inc(gap_inc),
    .dly_clr(dly_clr), .dly_inc(dly_inc),
    .load(load), .set_stb(set_stb), .clr_out(clr_out)
  );

  tone_qual_outreg #(.DIG_W(DIG_W)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .load(load), .set_stb(set_stb), .clr_out(clr_out),
    .code(code_in), .digit(digit_out), .stb(digit_strobe)
  );

endmodule

// File: rtl/tone_qual_chk.sv
module tone_qual_chk #(
  parameter int DIG_W       = 4,
  parameter int PAUSE_TICKS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             tone,
  input logic [DIG_W-1:0] digit,
  input logic             stb
);

  logic [15:0] chk_gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_gap_q <= '0;
    end else if (tick) begin
      if (tone)                   chk_gap_q <= '0;
      else if (chk_gap_q != '1)   chk_gap_q <= chk_gap_q + 16'd1;
    end
  end

  p_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb) |-> $stable(digit));

  p_hold_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && (tone || !tick)) |=> (stb && $stable(digit)));

  p_dropout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && tick && !tone && (chk_gap_q < 16'(PAUSE_TICKS - 1))) |=> stb);

  p_pause_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && tick && !tone && (chk_gap_q >= 16'(PAUSE_TICKS - 1))) |=> (!stb && (digit == '0)));

  p_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(digit) && $stable(stb)));

endmodule

bind tone_qual tone_qual_chk #(.DIG_W(DIG_W), .PAUSE_TICKS(PAUSE_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .tone(tone_present),
  .digit(digit_out), .stb(digit_strobe)
);

// File: tb/sim_tone_qual.sv
module sim_tone_qual;

  localparam int CLK_P = 10;
  localparam int DW    = 4;
  localparam int ACC   = 6;
  localparam int STB   = 3;
  localparam int PAUSE = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          tone = 1'b0;
  logic [DW-1:0] code = '0;
  logic [DW-1:0] digit_out;
  logic          digit_strobe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  string cur_req = "R1";

  int            m_run, m_gap, m_dly;
  bit            m_acc, m_stb;
  logic [DW-1:0] m_dig;

  tone_qual #(.DIG_W(DW), .ACC_TICKS(ACC), .STB_TICKS(STB), .PAUSE_TICKS(PAUSE)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tone_present(tone), .code_in(code),
    .digit_out(digit_out), .digit_strobe(digit_strobe)
  );

  always #(CLK_P/2) clk = ~clk;

  // Reference model written from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_gap = 0; m_dly = 0; m_acc = 0; m_stb = 0; m_dig = '0;
    end else if (tick) begin
      if (!m_acc) begin
        if (tone) begin
          if (m_run + 1 >= ACC) begin
            m_acc = 1; m_dig = code; m_run = 0; m_gap = 0; m_dly = 0;
          end else m_run = m_run + 1;
        end else m_run = 0;
      end else begin
        if (!tone && (m_gap + 1 >= PAUSE)) begin
          m_acc = 0; m_stb = 0; m_dig = '0; m_run = 0;
        end else begin
          m_gap = tone ? 0 : m_gap + 1;
          if (!m_stb) begin
            if (m_dly + 1 >= STB) m_stb = 1;
            else m_dly = m_dly + 1;
          end
        end
      end
    end
  end

  function automatic bit same(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a === b;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (!same(act, exp)) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check({cur_req, " digit"}, digit_out, m_dig);
      check({cur_req, " strobe"}, {{(DW-1){1'b0}}, digit_strobe}, {{(DW-1){1'b0}}, m_stb});
    end
  end

  task automatic step(input bit t, input bit p, input logic [DW-1:0] c);
    @(negedge clk);
    tick = t; tone = p; code = c;
  endtask

  task automatic ticks(input int n, input bit p, input logic [DW-1:0] c);
    for (int i = 0; i < n; i++) step(1'b1, p, c);
    step(1'b0, p, c);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 reset digit", digit_out, '0);
    check("R1 reset strobe", {3'b0, digit_strobe}, '0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, '0);
    check("R1 after release", {digit_out[2:0], digit_strobe}, '0);

    // R2: burst one tick short of acceptance
    cur_req = "R2";
    ticks(ACC - 1, 1'b1, 4'hA);
    check("R2 short burst digit", digit_out, '0);
    check("R2 short burst strobe", {3'b0, digit_strobe}, '0);
    ticks(PAUSE + 1, 1'b0, 4'hA);

    // R3: acceptance on the ACC-th tick, code 0x5
    cur_req = "R3";
    ticks(ACC, 1'b1, 4'h5);
    check("R3 digit latched", digit_out, 4'h5);
    check("R3 strobe still low", {3'b0, digit_strobe}, '0);

    // R4/R5: strobe on the STB-th tick, new code ignored
    cur_req = "R4";
    ticks(STB - 1, 1'b1, 4'h9);
    check("R4 strobe not yet", {3'b0, digit_strobe}, '0);
    ticks(1, 1'b1, 4'h9);
    check("R4 strobe risen", {3'b0, digit_strobe}, 4'h1);
    check("R5 code held", digit_out, 4'h5);

    // R6: dropout one tick short of the pause
    cur_req = "R6";
    ticks(PAUSE - 1, 1'b0, 4'h2);
    check("R6 strobe kept", {3'b0, digit_strobe}, 4'h1);
    check("R6 digit kept", digit_out, 4'h5);
    ticks(2, 1'b1, 4'h2);

    // R7: full pause clears
    cur_req = "R7";
    ticks(PAUSE - 1, 1'b0, 4'h2);
    check("R7 not cleared yet", {3'b0, digit_strobe}, 4'h1);
    ticks(1, 1'b0, 4'h2);
    check("R7 strobe cleared", {3'b0, digit_strobe}, '0);
    check("R7 digit cleared", digit_out, '0);

    // R8: tone present without ticks
    cur_req = "R8";
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 4'h3);
    check("R8 no tick digit", digit_out, '0);
    check("R8 no tick strobe", {3'b0, digit_strobe}, '0);
    ticks(PAUSE + 1, 1'b0, '0);

    // Code 0 accepted: strobe still follows (R4)
    cur_req = "R4 zero code";
    ticks(ACC + STB, 1'b1, 4'h0);
    check("R4 strobe for code 0", {3'b0, digit_strobe}, 4'h1);
    ticks(PAUSE, 1'b0, '0);

    // Random bursts, gaps and tick density
    cur_req = "R2 R3 R4 R5 R6 R7 R8 random";
    for (int b = 0; b < 200; b++) begin
      int on_n, off_n;
      logic [DW-1:0] c;
      on_n  = 1 + int'($urandom % 14);
      off_n = 1 + int'($urandom % 8);
      c     = DW'($urandom);
      for (int k = 0; k < on_n; k++) begin
        if ($urandom % 3 == 0) step(1'b0, 1'b1, DW'($urandom));
        if ($urandom % 4 == 0) c = DW'($urandom);
        step(1'b1, 1'b1, c);
      end
      for (int k = 0; k < off_n; k++) begin
        if ($urandom % 3 == 0) step(1'b0, $urandom % 2 == 0, c);
        step(1'b1, 1'b0, c);
      end
    end
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);
    finish_run();
  end

endmodule